// File: doc/BRIEF.md
# Prescaled Capture Timer

This block is a single timer channel. A programmable clock divider feeds a 24-bit up-counter. Each increment is compared with a compare register. When an increment would reach the compare value, the counter returns to zero and a timeout flag is raised. That flag can drive an interrupt line, and it can also raise a wakeup flag.

Instead of the divided clock, the counter can advance on edges of an event pin, and software chooses which edge polarity counts. A capture pin is watched for a selectable edge kind. On each qualifying edge the block does one of two things, chosen by a mode bit: it copies the live count into a capture register, or it zeroes the counter. In both cases it raises a capture flag.

Software controls the block through a register write/read port. Both pins are asynchronous and pass through a two-flop synchroniser before edge detection.

Top module: `prescaled_capture_timer`

## Requirements
- R1: After reset, every readable register (control at address 0, compare at 1, count at 2, capture at 3, flags at 4) reads 0, and `timeoutIrq`, `captureIrq` and `wakeFlag` are low.
- R2: In internal mode, with the run bit (control bit 0) set and divider value P in control bits 23:16, the count advances once every P+1 clocks. The first advance comes P+1 clocks after the write that enables counting.
- R3: When an increment would make the count equal to the compare value (address 1, bits 23:0), the count becomes 0 instead and the timeout flag (flags bit 0) is set.
- R4: `timeoutIrq` is high exactly when the timeout flag and the timeout interrupt enable (control bit 7) are both set. A timeout sets the wakeup flag (flags bit 2, also driven on `wakeFlag`) only if wake enable (control bit 9) is set.
- R5: While the run bit is clear, the count holds its value.
- R6: Writing control with bit 10 set zeroes the count and the divider at that clock edge. Bit 10 is not stored and always reads 0.
- R7: With external mode (control bit 1) set, the count advances once per event-pin edge: a rising edge if control bit 2 is 1, a falling edge if it is 0. The advance happens on the third clock edge after the pin changes.
- R8: With capture enable (control bit 3) clear, capture-pin edges change neither the capture register, the count nor the capture flag.
- R9: The capture edge field (control bits 6:5) selects 00 falling, 01 rising, 10 both, and 11 no edges. The capture action takes place on the third clock edge after the pin changes.
- R10: With capture mode (control bit 4) at 0, a capture event copies into the capture register (address 3) the count as it stood before that edge. With the bit at 1, the capture event zeroes the count and leaves the capture register unchanged.
- R11: Every capture event sets the capture flag (flags bit 1). `captureIrq` is high exactly when that flag and the capture interrupt enable (control bit 8) are both set.
- R12: Writing 1 to a bit of the flags register clears that flag. If a flag is set in the same cycle as the clear, it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data (combinational) |
| eventPin | input | 1 | Asynchronous external count input |
| capturePin | input | 1 | Asynchronous capture input |
| timeoutIrq | output | 1 | Gated timeout interrupt |
| captureIrq | output | 1 | Gated capture interrupt |
| wakeFlag | output | 1 | Wakeup flag state |

## Verification
Two actions can land on the same clock edge: a compare match setting the timeout flag, and a software write-one-to-clear of that same flag. The bench places a flag-clear write exactly on the edge where the count wraps. The flag must read as set afterwards. A later clear with no wrap on that edge must then empty it. A second collision comes from a capture edge that zeroes the counter while the counter is also stepping; the bench judges it by the count reading 1 one clock after the clearing edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_CMP  = 3'd1;
  localparam logic [2:0] ADR_CNT  = 3'd2;
  localparam logic [2:0] ADR_CAP  = 3'd3;
  localparam logic [2:0] ADR_FLAG = 3'd4;

  localparam int B_RUN    = 0;
  localparam int B_EXT    = 1;
  localparam int B_EXTRIS = 2;
  localparam int B_CAPEN  = 3;
  localparam int B_CAPCLR = 4;
  localparam int B_EDGE   = 5;
  localparam int B_TOIE   = 7;
  localparam int B_CAPIE  = 8;
  localparam int B_WKEN   = 9;
  localparam int B_RST    = 10;
  localparam int B_PRE    = 16;

  typedef struct packed {
    logic clearCount;
    logic captureClear;
    logic captureLoad;
    logic step;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], pin};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              evRise,
  input  logic              evFall,
  input  logic              capRise,
  input  logic              capFall,
  input  logic              hit,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  capVal,
  output logic [CNT_W-1:0]  cmpVal,
  output tmrStrobe_t        strobe,
  output logic              timeoutIrq,
  output logic              captureIrq,
  output logic              wakeFlag
);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'((1 << B_RST) - 1) | (DATA_W'((1 << PRE_W) - 1) << B_PRE);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] ctrlQ;
  logic [PRE_W-1:0]  presCnt;
  logic              toFlag, capFlag, wkFlag;
  logic              ctrlWr, flagWr, rstPulse, presTick, evEdge, capHit, capEvent;
  logic              runEn, extMode, capEn;
  logic [PRE_W-1:0]  preVal;

  assign runEn   = ctrlQ[B_RUN];
  assign extMode = ctrlQ[B_EXT];
  assign capEn   = ctrlQ[B_CAPEN];
  assign preVal  = ctrlQ[B_PRE +: PRE_W];

  assign ctrlWr   = wrEn && (wrAddr == ADR_CTRL);
  assign flagWr   = wrEn && (wrAddr == ADR_FLAG);
  assign rstPulse = ctrlWr && wrData[B_RST];
  assign presTick = runEn && !extMode && (presCnt >= preVal);
  assign evEdge   = ctrlQ[B_EXTRIS] ? evRise : evFall;

  always_comb begin
    case (ctrlQ[B_EDGE +: 2])
      2'b00:   capHit = capFall;
      2'b01:   capHit = capRise;
      2'b10:   capHit = capRise | capFall;
      default: capHit = 1'b0;
    endcase
  end
  assign capEvent = capEn && capHit;

  assign strobe.clearCount   = rstPulse;
  assign strobe.captureClear = capEvent && ctrlQ[B_CAPCLR];
  assign strobe.captureLoad  = capEvent && !ctrlQ[B_CAPCLR];
  assign strobe.step         = runEn && (extMode ? evEdge : presTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      cmpVal  <= '0;
      presCnt <= '0;
      toFlag  <= 1'b0;
      capFlag <= 1'b0;
      wkFlag  <= 1'b0;
    end else begin
      if (ctrlWr) ctrlQ <= wrData & CTRL_MASK;
      if (wrEn && (wrAddr == ADR_CMP)) cmpVal <= wrData[CNT_W-1:0];
      if (rstPulse)               presCnt <= '0;
      else if (runEn && !extMode) presCnt <= presTick ? '0 : presCnt + 1'b1;
      toFlag  <= (toFlag  & ~(flagWr & wrData[0])) | hit;
      capFlag <= (capFlag & ~(flagWr & wrData[1])) | capEvent;
      wkFlag  <= (wkFlag  & ~(flagWr & wrData[2])) | (hit & ctrlQ[B_WKEN]);
    end
  end

  always_comb begin
    case (rdAddr)
      ADR_CTRL: rdData = ctrlQ;
      ADR_CMP:  rdData = {{PAD_W{1'b0}}, cmpVal};
      ADR_CNT:  rdData = {{PAD_W{1'b0}}, count};
      ADR_CAP:  rdData = {{PAD_W{1'b0}}, capVal};
      ADR_FLAG: rdData = {{(DATA_W-3){1'b0}}, wkFlag, capFlag, toFlag};
      default:  rdData = '0;
    endcase
  end

  assign timeoutIrq = toFlag & ctrlQ[B_TOIE];
  assign captureIrq = capFlag & ctrlQ[B_CAPIE];
  assign wakeFlag   = wkFlag;

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> toFlag);
  // R4
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wkFlag) |-> ($past(ctrlQ[B_WKEN]) && toFlag));
  // R8
  cap_flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capFlag) |-> $past(capEn));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capVal,
  output logic             hit
);
  logic [CNT_W-1:0] nextCount;
  logic             zeroReq;

  assign nextCount = count + 1'b1;
  assign zeroReq   = strobe.clearCount || strobe.captureClear;
  assign hit       = strobe.step && !zeroReq && (nextCount == cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      capVal <= '0;
    end else begin
      if (zeroReq)          count <= '0;
      else if (strobe.step) count <= hit ? '0 : nextCount;
      if (strobe.captureLoad) capVal <= count;
    end
  end

  // R6
  clear_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCount |=> (count == '0));
  // R10
  cap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureLoad |=> (capVal == $past(count)));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.step || zeroReq) |=> $stable(count));
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (count == '0));
endmodule

// File: rtl/prescaled_capture_timer.sv
module prescaled_capture_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int PRE_W   = 8,
  parameter int DATA_W  = 32,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              eventPin,
  input  logic              capturePin,
  output logic              timeoutIrq,
  output logic              captureIrq,
  output logic              wakeFlag
);
  logic             evRise, evFall, capRise, capFall, hit;
  logic [CNT_W-1:0] count, capVal, cmpVal;
  tmrStrobe_t       strobe;

  tmr_pin_edge #(.STAGES(SYNC_ST)) uEvEdge (
    .clk(clk), .rstN(rstN), .pin(eventPin), .rise(evRise), .fall(evFall));
  tmr_pin_edge #(.STAGES(SYNC_ST)) uCapEdge (
    .clk(clk), .rstN(rstN), .pin(capturePin), .rise(capRise), .fall(capFall));

  tmr_control #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evRise(evRise), .evFall(evFall),
    .capRise(capRise), .capFall(capFall), .hit(hit), .count(count),
    .capVal(capVal), .cmpVal(cmpVal), .strobe(strobe),
    .timeoutIrq(timeoutIrq), .captureIrq(captureIrq), .wakeFlag(wakeFlag));

  tmr_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpVal(cmpVal),
    .count(count), .capVal(capVal), .hit(hit));
endmodule

// File: tb/prescaled_capture_timer_test.sv
module prescaled_capture_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RUN = 32'h1, EXT = 32'h2, EXTR = 32'h4, CAPEN = 32'h8,
    CAPCLR = 32'h10, E_FALL = 32'h0, E_RISE = 32'h20, E_BOTH = 32'h40,
    E_NONE = 32'h60, TOIE = 32'h80, CAPIE = 32'h100, WKEN = 32'h200, RST = 32'h400;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, eventPin = 1'b0, capturePin = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic timeoutIrq, captureIrq, wakeFlag;
  int checks = 0, failures = 0;

  prescaled_capture_timer uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .eventPin(eventPin),
    .capturePin(capturePin), .timeoutIrq(timeoutIrq), .captureIrq(captureIrq),
    .wakeFlag(wakeFlag));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rdAddr = a; #1; v = rdData;
  endtask

  task automatic do_reset();
    eventPin = 1'b0; capturePin = 1'b0; wrEn = 1'b0;
    rstN = 1'b0; wait_n(3); rstN = 1'b1; wait_n(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 register zero", v, 0);
    end
    chk("R1 outputs low", {29'd0, timeoutIrq, captureIrq, wakeFlag}, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    do_reset();
    wr(1, 32'hFF_FFFF);
    wr(0, RUN | (32'd3 << 16));
    wait_n(20); rd(2, v); chk("R2 divide by 4 after 20 clocks", v, 5);
    wr(0, 32'd3 << 16);
    wait_n(6); rd(2, v); chk("R5 count holds while stopped", v, 5);
    wr(0, RUN | RST | (32'd3 << 16));
    rd(2, v); chk("R6 counter cleared", v, 0);
    rd(0, v); chk("R6 reset bit reads zero", v, RUN | (32'd3 << 16));
    wait_n(3); rd(2, v); chk("R6 divider cleared, 3 clocks", v, 0);
    wait_n(1); rd(2, v); chk("R6 divider cleared, 4 clocks", v, 1);
  endtask

  task automatic t_compare();
    logic [31:0] v;
    do_reset();
    wr(1, 5);
    wr(0, RUN);
    wait_n(4); rd(2, v); chk("R3 count before match", v, 4);
    rd(4, v); chk("R3 no flag before match", v, 0);
    wait_n(1); rd(2, v); chk("R3 count wraps at compare", v, 0);
    rd(4, v); chk("R3 timeout flag set", v, 1);
    chk("R4 irq gated off", {31'd0, timeoutIrq}, 0);
    chk("R4 no wake without enable", {31'd0, wakeFlag}, 0);
    wait_n(4);
    wr(4, 7);
    rd(4, v); chk("R12 set wins over clear", v, 1);
    wr(4, 1);
    rd(4, v); chk("R12 write one clears", v, 0);
    wr(0, RUN | TOIE | WKEN);
    wait_n(3); rd(4, v); chk("R4 timeout and wake flags", v, 5);
    chk("R4 irq when enabled", {31'd0, timeoutIrq}, 1);
    chk("R4 wake output", {31'd0, wakeFlag}, 1);
  endtask

  task automatic ext_pattern();
    for (int i = 0; i < 3; i++) begin
      eventPin = 1'b1; wait_n(4);
      eventPin = 1'b0; wait_n(4);
    end
    eventPin = 1'b1; wait_n(6);
  endtask

  task automatic t_ext();
    logic [31:0] v;
    do_reset();
    wr(1, 32'hFF_FFFF);
    wr(0, RUN | EXT);
    ext_pattern();
    rd(2, v); chk("R7 falling edges counted", v, 3);
    do_reset();
    wr(1, 32'hFF_FFFF);
    wr(0, RUN | EXT | EXTR);
    ext_pattern();
    rd(2, v); chk("R7 rising edges counted", v, 4);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    do_reset();
    wr(1, 32'hFF_FFFF);
    wr(0, RUN | CAPIE | E_RISE);
    capturePin = 1'b1; wait_n(5); capturePin = 1'b0; wait_n(5);
    rd(3, v); chk("R8 disabled capture register", v, 0);
    rd(4, v); chk("R8 disabled capture flag", v, 0);
    chk("R8 no capture irq", {31'd0, captureIrq}, 0);

    do_reset();
    wr(1, 32'hFF_FFFF);
    wr(0, RUN | CAPEN | CAPIE | E_RISE);
    wait_n(10); capturePin = 1'b1; wait_n(4);
    rd(3, v); chk("R10 latched count on rise", v, 12);
    rd(4, v); chk("R11 capture flag", v, 2);
    chk("R11 capture irq", {31'd0, captureIrq}, 1);
    wr(4, 2);
    capturePin = 1'b0; wait_n(5);
    rd(3, v); chk("R9 rising only, fall ignored", v, 12);
    rd(4, v); chk("R9 no flag on fall", v, 0);

    do_reset();
    wr(1, 32'hFF_FFFF);
    wr(0, RUN | CAPEN | E_BOTH);
    wait_n(10); capturePin = 1'b1; wait_n(4);
    rd(3, v); chk("R9 both edges, rise", v, 12);
    capturePin = 1'b0; wait_n(4);
    rd(3, v); chk("R9 both edges, fall", v, 16);

    do_reset();
    wr(1, 32'hFF_FFFF);
    wr(0, RUN | CAPEN | E_FALL);
    wait_n(10); capturePin = 1'b1; wait_n(4);
    rd(3, v); chk("R9 falling select ignores rise", v, 0);
    capturePin = 1'b0; wait_n(4);
    rd(3, v); chk("R9 falling select", v, 16);

    do_reset();
    wr(1, 32'hFF_FFFF);
    wr(0, RUN | CAPEN | E_NONE);
    capturePin = 1'b1; wait_n(5); capturePin = 1'b0; wait_n(5);
    rd(3, v); chk("R9 select 11 captures nothing", v, 0);
    rd(4, v); chk("R9 select 11 no flag", v, 0);
  endtask

  task automatic t_capture_clear();
    logic [31:0] v;
    do_reset();
    wr(1, 32'hFF_FFFF);
    wr(0, RUN | CAPEN | CAPCLR | E_RISE);
    wait_n(10); capturePin = 1'b1; wait_n(4);
    rd(2, v); chk("R10 capture clears count", v, 1);
    rd(3, v); chk("R10 clear mode leaves capture reg", v, 0);
    rd(4, v); chk("R11 flag in clear mode", v, 2);
    chk("R11 irq gated off", {31'd0, captureIrq}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_prescale();
    t_compare();
    t_ext();
    t_capture();
    t_capture_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule